// File: doc/BRIEF.md
# Attached Device Characteristics Table

This block keeps a small record for every 7-bit bus address a serial bus controller can reach. Each record says whether a target at that address is attached, whether it is a legacy I2C target, and two in-band interrupt capability flags copied from the target's bus characteristics byte. Software reaches the table through one 32-bit configuration word. A write whose write-enable bit is clear only selects a record, and the readback word then shows that record. A write whose write-enable bit is set stores new flags into the record at the given address. Read-modify-write therefore needs only one register address.

The bus engine has a separate lookup port. It presents an address and gets that record's flags back in the same cycle. With those flags it decides whether to accept an in-band interrupt from that address, and whether a data byte follows the interrupt. The table admits at most 15 attached targets, because one of 16 device slots is reserved for the controller itself.

Top module: `dev_char_table`

## Requirements
- R1: After reset every record reads as all-zero flags (not attached), the selected address is 0, and the readback word is 0.
- R2: A configuration write with bit 8 clear changes no record. It only latches bits 15:9 as the selected address, and from the next cycle the readback shows that record's flags.
- R3: A configuration write with bit 8 set stores bits 3:0 into the record addressed by bits 15:9 and also selects that record. The flag encoding is: bit 0 legacy I2C, bit 1 attached, bit 2 interrupt-request capable, bit 3 interrupt carries a data byte. The new flags are visible on readback and lookup from the next cycle.
- R4: The readback word holds the selected address in bits 15:9 and that record's flags in bits 3:0. Bit 8, bits 7:4 and bits 31:16 always read as zero.
- R5: The lookup port returns the attached flag, the legacy flag and the two capability flags of the queried address in the same cycle, with no register in the path.
- R6: The interrupt-accept output is 1 only when the queried record is attached, is not legacy I2C, and has its request-capable flag set. The payload output is 1 only when accept is 1 and the data-byte flag is set.
- R7: Writing an address with bit 8 set and bit 1 clear detaches that record, and the slot it used becomes free again.
- R8: At most 15 records may be attached at once. A write that would attach a not-yet-attached record while 15 are attached is dropped: the record stays unchanged, but the address is still selected. A write to a record that is already attached is always stored.
- R9: A target is moved to a new address in two writes, a detach at the old address followed by an attach at the new one. After the two writes the old address reads as not attached and the new address reads as attached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected record |
| qry_addr | input | 7 | Address queried by the bus engine |
| qry_attached | output | 1 | Queried record is attached |
| qry_legacy | output | 1 | Queried record is a legacy I2C target |
| qry_ibi_caps | output | 2 | Queried record's capability flags (bit 0 request capable, bit 1 data byte) |
| qry_ibi_accept | output | 1 | Interrupt from the queried address may be accepted |
| qry_ibi_payload | output | 1 | An accepted interrupt carries a data byte |

## Verification
A configuration write takes effect at the clock edge on which it is sampled. Its effect on the readback word and on the lookup outputs is therefore due one cycle after the strobe. The lookup outputs follow the query address combinationally, within the same cycle. The bench drives every write on a falling edge and drops the strobe on the next falling edge. It then samples the readback and the lookup at that second falling edge, after one rising edge has passed. For lookup-only checks it moves the query address and samples a short delay later, with no clock edge in between.

// File: rtl/dev_char_table.sv
module dev_char_table #(
  parameter int ADDR_W  = 7,
  parameter int MAX_DEV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_attached,
  output logic              qry_legacy,
  output logic [1:0]        qry_ibi_caps,
  output logic              qry_ibi_accept,
  output logic              qry_ibi_payload
);
  localparam int ENTRIES  = 1 << ADDR_W;
  localparam int LIMIT    = MAX_DEV - 1;
  localparam int CNT_W    = $clog2(MAX_DEV + 1);
  localparam int WEN_BIT  = 8;
  localparam int ADDR_LSB = 9;
  localparam int TOP_PAD  = 32 - ADDR_LSB - ADDR_W;

  logic [3:0]        tbl [ENTRIES];
  logic [ADDR_W-1:0] sel;
  logic [CNT_W-1:0]  n_att;

  logic [ADDR_W-1:0] w_addr;
  logic [3:0]        w_flags;
  logic              w_en, cur_att, full, attach, detach, commit;
  logic [3:0]        q;
  logic              unused_wdata;

  assign w_addr  = cfg_wdata[ADDR_LSB +: ADDR_W];
  assign w_flags = cfg_wdata[3:0];
  assign w_en    = cfg_wr && cfg_wdata[WEN_BIT];
  assign cur_att = tbl[w_addr][1];
  assign full    = (n_att == CNT_W'(LIMIT));
  assign attach  = w_en && w_flags[1] && !cur_att;
  assign detach  = w_en && !w_flags[1] && cur_att;
  assign commit  = w_en && !(attach && full);
  assign unused_wdata = ^{cfg_wdata[31:ADDR_LSB+ADDR_W], cfg_wdata[7:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 4'b0;
      sel   <= '0;
      n_att <= '0;
    end else begin
      if (cfg_wr) sel <= w_addr;
      if (commit) tbl[w_addr] <= w_flags;
      if (attach && !full) n_att <= n_att + 1'b1;
      else if (detach)     n_att <= n_att - 1'b1;
    end
  end

  assign cfg_rdata = {{TOP_PAD{1'b0}}, sel, 5'b0, tbl[sel]};

  assign q               = tbl[qry_addr];
  assign qry_legacy      = q[0];
  assign qry_attached    = q[1];
  assign qry_ibi_caps    = q[3:2];
  assign qry_ibi_accept  = q[1] && !q[0] && q[2];
  assign qry_ibi_payload = qry_ibi_accept && q[3];
endmodule

module dev_char_table_chk #(
  parameter int ADDR_W  = 7,
  parameter int MAX_DEV = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_wr,
  input logic [31:0]                  cfg_wdata,
  input logic [31:0]                  cfg_rdata,
  input logic                         qry_attached,
  input logic                         qry_legacy,
  input logic [1:0]                   qry_ibi_caps,
  input logic                         qry_ibi_accept,
  input logic                         qry_ibi_payload,
  input logic [$clog2(MAX_DEV+1)-1:0] n_att
);
  localparam int LIMIT = MAX_DEV - 1;

  p_count_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    n_att <= LIMIT);

  p_rd_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:16] == 16'b0 && cfg_rdata[8:4] == 5'b0);

  p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata[9 +: ADDR_W] == $past(cfg_wdata[9 +: ADDR_W]));

  p_select_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_wdata[8] |=> $stable(n_att));

  p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[8] && !(cfg_wdata[1] && n_att == LIMIT)
    |=> cfg_rdata[3:0] == $past(cfg_wdata[3:0]));

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qry_ibi_accept |-> qry_attached && !qry_legacy && qry_ibi_caps[0]);

  p_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qry_ibi_payload |-> qry_ibi_accept && qry_ibi_caps[1]);
endmodule

bind dev_char_table dev_char_table_chk #(.ADDR_W(ADDR_W), .MAX_DEV(MAX_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .qry_attached(qry_attached), .qry_legacy(qry_legacy),
  .qry_ibi_caps(qry_ibi_caps), .qry_ibi_accept(qry_ibi_accept),
  .qry_ibi_payload(qry_ibi_payload), .n_att(n_att)
);

// File: tb/dev_char_table_bench.sv
`timescale 1ns/1ps
module dev_char_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [6:0]  qry_addr = '0;
  logic        qry_attached, qry_legacy, qry_ibi_accept, qry_ibi_payload;
  logic [1:0]  qry_ibi_caps;

  dev_char_table u_dev_char_table (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .qry_addr(qry_addr), .qry_attached(qry_attached),
    .qry_legacy(qry_legacy), .qry_ibi_caps(qry_ibi_caps),
    .qry_ibi_accept(qry_ibi_accept), .qry_ibi_payload(qry_ibi_payload)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [3:0] m_tbl [128];
  logic [6:0] m_sel;
  int         m_cnt;

  function automatic logic [31:0] mk(input logic [6:0] a, input logic [3:0] f, input bit wen);
    return {16'b0, a, wen, 4'b0, f};
  endfunction

  function automatic logic [5:0] q_exp(input logic [3:0] f);
    logic acc;
    acc = f[1] && !f[0] && f[2];
    return {acc && f[3], acc, f[3:2], f[0], f[1]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 128; i++) m_tbl[i] = 4'b0;
    m_sel = '0;
    m_cnt = 0;
  endtask

  task automatic model_apply(input logic [31:0] d);
    logic [6:0] a;
    bit att;
    a = d[15:9];
    m_sel = a;
    if (d[8]) begin
      att = d[1] && !m_tbl[a][1];
      if (!(att && m_cnt == 15)) begin
        if (att) m_cnt++;
        else if (!d[1] && m_tbl[a][1]) m_cnt--;
        m_tbl[a] = d[3:0];
      end
    end
  endtask

  task automatic chk_rd(input string tag);
    logic [31:0] e;
    e = {16'b0, m_sel, 5'b0, m_tbl[m_sel]};
    check(cfg_rdata === e, tag, cfg_rdata, e);
  endtask

  task automatic chk_q(input logic [6:0] a, input string tag);
    logic [5:0] act, e;
    qry_addr = a;
    #1;
    act = {qry_ibi_payload, qry_ibi_accept, qry_ibi_caps, qry_legacy, qry_attached};
    e = q_exp(m_tbl[a]);
    check(act === e, tag, {26'b0, act}, {26'b0, e});
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    model_apply(d);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk_rd(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    do_reset();
    chk_rd("R1 reset readback");
    for (int i = 0; i < 128; i++) chk_q(7'(i), "R1 reset lookup");

    wr(mk(7'h05, 4'b0110, 1'b1), "R3 attach 0x05");
    chk_q(7'h05, "R6 accept without payload");
    wr(mk(7'h05, 4'b1110, 1'b1), "R3 update 0x05 with data byte");
    chk_q(7'h05, "R6 accept with payload");
    wr(mk(7'h09, 4'b0111, 1'b1), "R3 attach legacy 0x09");
    chk_q(7'h09, "R6 legacy never accepted");
    wr(mk(7'h0a, 4'b1010, 1'b1), "R3 attach 0x0a not request capable");
    chk_q(7'h0a, "R6 no request capability");
    wr(mk(7'h05, 4'b0001, 1'b0), "R2 select 0x05 ignores flags");
    chk_q(7'h05, "R2 record unchanged after select");
    wr(mk(7'h09, 4'b1111, 1'b0), "R4 select echoes address");
    chk_q(7'h5a, "R5 lookup of empty record");
    chk_q(7'h09, "R5 lookup same cycle");

    wr(mk(7'h05, 4'b0000, 1'b1), "R9 detach old address");
    wr(mk(7'h20, 4'b0110, 1'b1), "R9 attach new address");
    chk_q(7'h05, "R9 old address detached");
    chk_q(7'h20, "R9 new address attached");

    do_reset();
    chk_rd("R1 second reset readback");
    chk_q(7'h20, "R1 second reset clears record");

    for (int i = 0; i < 15; i++) wr(mk(7'(8'h10 + i), 4'b0110, 1'b1), "R8 fill slots");
    wr(mk(7'h7f, 4'b0110, 1'b1), "R8 sixteenth attach dropped");
    chk_q(7'h7f, "R8 dropped record stays detached");
    wr(mk(7'h7e, 4'b0101, 1'b1), "R8 unattached flag write while full");
    wr(mk(7'h10, 4'b1110, 1'b1), "R8 update of attached record kept");
    wr(mk(7'h10, 4'b0000, 1'b1), "R7 detach frees slot");
    chk_q(7'h10, "R7 detached lookup");
    wr(mk(7'h7f, 4'b0110, 1'b1), "R7 attach after free");
    chk_q(7'h7f, "R7 freed slot reused");

    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [6:0] a;
      logic [3:0] f;
      bit wen;
      a = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 24);
      f = 4'($urandom);
      wen = ($urandom % 4) != 0;
      wr(mk(a, f, wen) | {16'b0, 16'b0} | (wen ? 32'b0 : {16'h0, 7'h0, 1'b0, 4'($urandom), 4'b0}),
         wen ? "R3 random write" : "R2 random select");
      chk_q(7'($urandom % 24), "R5 random lookup");
      chk_q(a, "R6 random lookup of written address");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule